// File: doc/BRIEF.md
# Bloom-Filter Landing-Site Source Checker

This block checks forward-edge control flow at the landing sites of indirect branches. A core issues a *set* request before an indirect jump. The request carries the section identifier (SID) of the code the jump leaves from. The block holds that SID in a one-entry branch-state register. When the jump lands, the core issues a *check* request. That request carries the landing site's authorization filter, a 256-bit Bloom filter vector. The block hashes the held SID into four bit positions, tests them against the filter, and reports pass or violation.

The SID is opaque to the block, so the same hardware serves per-function and per-basic-block sections. The check always probes exactly four filter bits. Its latency is therefore the same however many sources the filter admits. Each check consumes the held SID, so one set authorizes at most one landing.

Top module: `bl_landing_check`

## Requirements
- R1: After reset, `res_valid`, `res_pass` and `res_viol` are 0, `req_ready` is 1, and the branch-state register is empty.
- R2: A set request is accepted in a cycle where `req_valid` and `req_ready` are both 1 and `req_op` is 0. It loads `req_sid` into the branch-state register and marks the register as full. A set never produces a result pulse.
- R3: A check request has `req_op` equal to 1. It derives four probe indices from the held 16-bit SID `s`. First, h1 is `s[7:0] ^ s[15:8]`. Second, `r` is `s` rotated left by 3 bits, and h2 is `(r[7:0] ^ r[15:8]) | 1`. Probe i, for i = 0 to 3, is `(h1 + i*h2) mod 256`.
- R4: A check on a full register passes only when every probed bit of `req_filter` is 1, where bit n of the filter is `req_filter[n]`.
- R5: If any probed filter bit is 0, the check reports a violation.
- R6: A check issued while the branch-state register is empty reports a violation, whatever the filter holds.
- R7: Every accepted check empties the branch-state register, so a second check without a new set reports a violation.
- R8: An accepted check in cycle t gives a one-cycle pulse on `res_valid` in cycle t+3. During that pulse exactly one of `res_pass` and `res_viol` is 1. Both flags are 0 whenever `res_valid` is 0.
- R9: `req_ready` is 0 in the two cycles after an accepted check. A request offered in those cycles is not accepted and changes nothing.
- R10: Of several sets issued before a check, the check uses the SID of the most recent one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request can be accepted this cycle |
| req_op | input | 1 | 0 = set SID, 1 = check against filter |
| req_sid | input | 16 | Source section identifier for a set |
| req_filter | input | 256 | Landing-site Bloom filter for a check |
| res_valid | output | 1 | One-cycle result pulse |
| res_pass | output | 1 | Source authorized |
| res_viol | output | 1 | Control-flow violation |

## Verification
The assertions assume that a requester offers work only through the valid/ready handshake. They also assume that at most one operation, set or check, reaches the branch-state register in any cycle. The single-pulse property relies on the two stall cycles that follow each check. The stimulus changes inputs only after a clock edge. It holds a request until it has been accepted, except in one deliberate case: a set is offered for a single cycle while `req_ready` is low, to show that the offer has no effect. Filters are built from the stated index formula, either with exactly the four probed bits set or with one of those bits cleared. Random dense, all-zero and all-one filters are also used, on SIDs that include 0 and 16'hFFFF.

// File: rtl/bl_pkg.sv
// Package: shared request encoding for the landing-site checker.
// Assumes: a single request bit selects between set and check.
package bl_pkg;
    typedef enum logic {
        OP_SET   = 1'b0,
        OP_CHECK = 1'b1
    } bl_op_e;
endpackage

// File: rtl/bl_state_reg.sv
// Module: one-entry branch-state register holding the pending source SID.
// Assumes: set_en and take_en are never high in the same cycle; take_en
// consumes the entry, so each SID authorizes a single landing.
module bl_state_reg #(
    parameter int SID_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             set_en,
    input  logic [SID_W-1:0] set_sid,
    input  logic             take_en,
    output logic [SID_W-1:0] sid_q,
    output logic             vld_q
);
    // Purpose: load on set, clear the valid bit on check, empty on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sid_q <= '0;
            vld_q <= 1'b0;
        end else if (set_en) begin
            sid_q <= set_sid;
            vld_q <= 1'b1;
        end else if (take_en) begin
            vld_q <= 1'b0;
        end
    end

    AST_SET_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
        set_en |=> (vld_q && sid_q == $past(set_sid))); // R2
    AST_TAKE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        take_en |=> !vld_q); // R7
    AST_OPS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(set_en && take_en)); // R2
endmodule

// File: rtl/bl_hash.sv
// Module: double-hashing probe index generator.
// Assumes: SID_W is a multiple of IDX_W and greater than ROT. h1 is the XOR fold
// of the SID. h2 is the XOR fold of the SID rotated left by ROT, forced odd so
// the probes are distinct when the filter width is a power of two.
module bl_hash #(
    parameter int SID_W  = 16,
    parameter int IDX_W  = 8,
    parameter int NPROBE = 4,
    parameter int ROT    = 3
) (
    input  logic [SID_W-1:0]        sid,
    output logic [NPROBE*IDX_W-1:0] idx_flat
);
    localparam int NCHUNK = SID_W / IDX_W;

    logic [SID_W-1:0] sid_rot;
    logic [IDX_W-1:0] h1;
    logic [IDX_W-1:0] h2_raw;
    logic [IDX_W-1:0] h2;

    assign sid_rot = {sid[SID_W-1-ROT:0], sid[SID_W-1:SID_W-ROT]};

    // Purpose: fold both SID views into index-wide hashes.
    always_comb begin
        h1     = '0;
        h2_raw = '0;
        for (int c = 0; c < NCHUNK; c++) begin
            h1     = h1 ^ sid[c*IDX_W +: IDX_W];
            h2_raw = h2_raw ^ sid_rot[c*IDX_W +: IDX_W];
        end
    end

    assign h2 = h2_raw | {{(IDX_W-1){1'b0}}, 1'b1};

    for (genvar i = 0; i < NPROBE; i++) begin : g_probe_idx
        localparam logic [IDX_W-1:0] STEP = IDX_W'(i);
        assign idx_flat[i*IDX_W +: IDX_W] = h1 + STEP * h2;
    end
endmodule

// File: rtl/bl_probe.sv
// Module: tests the filter bits selected by the probe indices.
// Assumes: FILT_W equals 2**IDX_W, so every index addresses a filter bit.
module bl_probe #(
    parameter int FILT_W = 256,
    parameter int IDX_W  = 8,
    parameter int NPROBE = 4
) (
    input  logic [FILT_W-1:0]       filter,
    input  logic [NPROBE*IDX_W-1:0] idx_flat,
    output logic                    all_set
);
    logic [NPROBE-1:0] bit_hit;

    for (genvar i = 0; i < NPROBE; i++) begin : g_bit
        assign bit_hit[i] = filter[idx_flat[i*IDX_W +: IDX_W]];
    end

    assign all_set = &bit_hit;
endmodule

// File: rtl/bl_landing_check.sv
// Module: top of the landing-site source checker.
// Stage 1 captures the held SID and the filter when a check is accepted.
// Stage 2 registers the probe indices. Stage 3 registers the verdict.
// A result therefore leaves three cycles after acceptance.
// Assumes: the requester follows valid/ready. New requests stall while a
// check occupies stage 1 or stage 2.
module bl_landing_check #(
    parameter int SID_W  = 16,
    parameter int FILT_W = 256,
    parameter int NPROBE = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_op,
    input  logic [SID_W-1:0]  req_sid,
    input  logic [FILT_W-1:0] req_filter,
    output logic              res_valid,
    output logic              res_pass,
    output logic              res_viol
);
    import bl_pkg::*;

    localparam int IDX_W = $clog2(FILT_W);
    localparam int IDXV  = NPROBE * IDX_W;

    logic              fire, set_fire, chk_fire;
    logic [SID_W-1:0]  st_sid;
    logic              st_vld;

    logic              s1_v, s1_ok;
    logic [SID_W-1:0]  s1_sid;
    logic [FILT_W-1:0] s1_filt;
    logic              s2_v, s2_ok;
    logic [IDXV-1:0]   s2_idx;
    logic [FILT_W-1:0] s2_filt;
    logic              s3_v, s3_pass;

    logic [IDXV-1:0]   hash_idx;
    logic              probe_ok;

    assign req_ready = !(s1_v || s2_v);
    assign fire      = req_valid && req_ready;
    assign set_fire  = fire && (bl_op_e'(req_op) == OP_SET);
    assign chk_fire  = fire && (bl_op_e'(req_op) == OP_CHECK);

    bl_state_reg #(.SID_W(SID_W)) u_state (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_en  (set_fire),
        .set_sid (req_sid),
        .take_en (chk_fire),
        .sid_q   (st_sid),
        .vld_q   (st_vld)
    );

    bl_hash #(.SID_W(SID_W), .IDX_W(IDX_W), .NPROBE(NPROBE), .ROT(3)) u_hash (
        .sid      (s1_sid),
        .idx_flat (hash_idx)
    );

    bl_probe #(.FILT_W(FILT_W), .IDX_W(IDX_W), .NPROBE(NPROBE)) u_probe (
        .filter   (s2_filt),
        .idx_flat (s2_idx),
        .all_set  (probe_ok)
    );

    // Purpose: stage 1, capture the held SID, its valid bit and the filter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_v    <= 1'b0;
            s1_ok   <= 1'b0;
            s1_sid  <= '0;
            s1_filt <= '0;
        end else begin
            s1_v <= chk_fire;
            if (chk_fire) begin
                s1_ok   <= st_vld;
                s1_sid  <= st_sid;
                s1_filt <= req_filter;
            end
        end
    end

    // Purpose: stage 2, register the probe indices beside the filter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s2_v    <= 1'b0;
            s2_ok   <= 1'b0;
            s2_idx  <= '0;
            s2_filt <= '0;
        end else begin
            s2_v <= s1_v;
            if (s1_v) begin
                s2_ok   <= s1_ok;
                s2_idx  <= hash_idx;
                s2_filt <= s1_filt;
            end
        end
    end

    // Purpose: stage 3, register the verdict for the one-cycle result pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s3_v    <= 1'b0;
            s3_pass <= 1'b0;
        end else begin
            s3_v    <= s2_v;
            s3_pass <= s2_v && s2_ok && probe_ok;
        end
    end

    assign res_valid = s3_v;
    assign res_pass  = s3_v && s3_pass;
    assign res_viol  = s3_v && !s3_pass;

    AST_RESULT_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> (res_pass ^ res_viol)); // R8
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !res_valid |-> (!res_pass && !res_viol)); // R8
    AST_RESULT_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> $past(chk_fire, 3)); // R8
    AST_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |=> !res_valid); // R8
    AST_BUSY_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        chk_fire |=> !req_ready); // R9
    AST_EMPTY_VIOL: assert property (@(posedge clk) disable iff (!rst_n)
        (chk_fire && !st_vld) |=> ##2 res_viol); // R6
endmodule

// File: tb/bl_landing_check_tb.sv
// Bench: a behavioural reference model tracks the held SID and the pending
// results, and it is compared with the outputs at every falling clock edge.
module bl_landing_check_tb;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         req_valid = 1'b0;
    logic         req_ready;
    logic         req_op = 1'b0;
    logic [15:0]  req_sid = '0;
    logic [255:0] req_filter = '0;
    logic         res_valid, res_pass, res_viol;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    string cur_tag = "R1";

    // Model state.
    logic [15:0] m_sid = '0;
    bit          m_vld = 1'b0;
    int          busy_until = 0;
    int          q_due[$];
    bit          q_pass[$];
    string       q_tag[$];

    always #2 clk = ~clk;

    bl_landing_check u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_op(req_op), .req_sid(req_sid), .req_filter(req_filter),
        .res_valid(res_valid), .res_pass(res_pass), .res_viol(res_viol)
    );

    function automatic int probe_at(input logic [15:0] s, input int i);
        logic [15:0] r;
        int h1, h2;
        h1 = int'(s[7:0] ^ s[15:8]);
        r  = {s[12:0], s[15:13]};
        h2 = int'(r[7:0] ^ r[15:8]) | 1;
        return (h1 + i * h2) % 256;
    endfunction

    function automatic bit ref_hit(input logic [15:0] s, input logic [255:0] f);
        for (int i = 0; i < 4; i++) if (!f[probe_at(s, i)]) return 1'b0;
        return 1'b1;
    endfunction

    function automatic logic [255:0] exact_filter(input logic [15:0] s);
        logic [255:0] f = '0;
        for (int i = 0; i < 4; i++) f[probe_at(s, i)] = 1'b1;
        return f;
    endfunction

    task automatic check(input bit ok, input string tag, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d (cycle %0d)", tag, what, act, exp, cyc);
        end
    endtask

    // Purpose: compare outputs with the model, then advance the model.
    always @(negedge clk) begin
        cyc++;
        if (!rst_n) begin
            m_vld = 1'b0; busy_until = cyc + 1;
            q_due.delete(); q_pass.delete(); q_tag.delete();
        end else begin
            check(req_ready == (cyc >= busy_until), "R9", "req_ready", req_ready, cyc >= busy_until);
            if (q_due.size() > 0 && q_due[0] == cyc) begin
                check(res_valid == 1'b1, "R8", "res_valid", res_valid, 1);
                check(res_pass == q_pass[0] && res_viol == !q_pass[0], q_tag[0], "res_pass",
                      res_pass, q_pass[0]);
                void'(q_due.pop_front()); void'(q_pass.pop_front()); void'(q_tag.pop_front());
            end else begin
                check(!res_valid && !res_pass && !res_viol, "R8", "idle flags",
                      {res_valid, res_pass, res_viol}, 0);
            end
            if (req_valid && req_ready) begin
                if (req_op == 1'b0) begin
                    m_sid = req_sid; m_vld = 1'b1;
                end else begin
                    q_due.push_back(cyc + 3);
                    q_pass.push_back(m_vld && ref_hit(m_sid, req_filter));
                    q_tag.push_back(cur_tag);
                    m_vld = 1'b0;
                    busy_until = cyc + 3;
                end
            end
        end
    end

    task automatic do_req(input bit op, input logic [15:0] s, input logic [255:0] f);
        @(posedge clk); #1;
        req_valid = 1'b1; req_op = op; req_sid = s; req_filter = f;
        forever begin
            @(negedge clk);
            if (req_ready) break;
        end
        @(posedge clk); #1;
        req_valid = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
    endtask

    initial begin
        #400000;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [255:0] f;
        logic [15:0]  s;
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;
        idle(2);
        // R1: the register is empty after reset, so a check fails.
        cur_tag = "R1"; do_req(1'b1, '0, '1);
        idle(4);
        // R2, R3, R4: an exact filter passes.
        cur_tag = "R4"; do_req(1'b0, 16'h1234, '0); do_req(1'b1, '0, exact_filter(16'h1234));
        cur_tag = "R3"; do_req(1'b0, 16'h0000, '0); do_req(1'b1, '0, exact_filter(16'h0000));
        do_req(1'b0, 16'hFFFF, '0); do_req(1'b1, '0, exact_filter(16'hFFFF));
        // R5: clearing any one probed bit yields a violation.
        cur_tag = "R5";
        for (int j = 0; j < 4; j++) begin
            f = exact_filter(16'hBEEF);
            f[probe_at(16'hBEEF, j)] = 1'b0;
            do_req(1'b0, 16'hBEEF, '0); do_req(1'b1, '0, f);
        end
        // R7: the SID is consumed by the check.
        cur_tag = "R7"; do_req(1'b0, 16'h0A0A, '0); do_req(1'b1, '0, '1); do_req(1'b1, '0, '1);
        // R6: an empty register fails even with an all-ones filter.
        cur_tag = "R6"; do_req(1'b1, '0, '1);
        // R10: the latest set wins.
        cur_tag = "R10"; do_req(1'b0, 16'h1111, '0); do_req(1'b0, 16'h7E57, '0);
        do_req(1'b1, '0, exact_filter(16'h7E57));
        do_req(1'b0, 16'h7E57, '0); do_req(1'b0, 16'h1111, '0);
        do_req(1'b1, '0, exact_filter(16'h7E57));
        // R9: a set offered while stalled is dropped.
        cur_tag = "R9"; do_req(1'b0, 16'h4242, '0); do_req(1'b1, '0, exact_filter(16'h4242));
        req_valid = 1'b1; req_op = 1'b0; req_sid = 16'h5555;
        @(posedge clk); #1 req_valid = 1'b0;
        idle(3);
        do_req(1'b1, '0, '1);
        idle(4);
        // Random mix; R3 hashing across many SIDs and filter shapes.
        cur_tag = "R3";
        for (int n = 0; n < 300; n++) begin
            s = 16'($urandom);
            case ($urandom % 5)
                0: f = exact_filter(s);
                1: begin f = exact_filter(s); f[probe_at(s, int'($urandom % 4))] = 1'b0; end
                2: f = {8{$urandom}};
                3: f = '0;
                default: f = {8{$urandom | $urandom}};
            endcase
            if ($urandom % 6 != 0) do_req(1'b0, s, '0);
            do_req(1'b1, '0, f);
            if ($urandom % 3 == 0) idle(1);
        end
        idle(6);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule